// File: doc/BRIEF.md
# Timer/counter with steerable prescaler

This block holds an 8-bit count that the processor can load and read back. The count advances either on instruction-cycle strobes or on edges of an external input pin, and the edge direction can be chosen. The external pin is brought into the clock domain by a two-flop synchronizer and then turned into one-cycle edge pulses. A single 8-bit divider is shared between two users. It can slow down the count, or it can produce a divided tick for a watchdog that sits outside the block. It never serves both at once.

A 6-bit option word configures the block. Bit 5 picks the source (0 for instruction cycles, 1 for the pin). Bit 4 picks the edge (0 for rising, 1 for falling). Bit 3 steers the divider (0 to the counter, 1 to the watchdog tick). Bits 2:0 (`S`) set the divide ratio to 2^(S+1). Every advance request reaches the count through a two-stage delay line.

After each load, a small state machine holds the count for two edges. Its states are `ST_RUN`, `ST_HOLD_A` and `ST_HOLD_B`. A load in any state goes to `ST_HOLD_A`. `ST_HOLD_A` always goes to `ST_HOLD_B`, `ST_HOLD_B` always goes to `ST_RUN`, and `ST_RUN` stays in `ST_RUN` while there is no load. The count may advance only in `ST_RUN`. A wrap from 0xFF to 0x00 sets a sticky overflow flag.

Top module: `tcount_unit`

## Requirements
- R1: While reset is asserted, `rd_data` is 0x00, and `ovf_flag` and `wdt_tick` are 0.
- R2: With `wr_en` high at a rising edge, `rd_data` shows `wr_data` after that edge. A load wins over any advance in the same cycle.
- R3: With option bit 5 = 0 and bit 3 = 1, the count rises by one per `cyc_en` strobe. A strobe sampled at edge E advances the count at edge E+2.
- R4: On the two rising edges that follow a load, the count does not advance. Advance requests that fall on those edges are dropped.
- R5: With option bits 5:4 = 10 and bit 3 = 1, the count rises by one per rising edge of `ext_pin`.
- R6: With option bits 5:4 = 11 and bit 3 = 1, the count rises by one per falling edge of `ext_pin`, and rising edges are ignored.
- R7: With option bit 3 = 0, the count advances once per 2^(S+1) source events, where S is option bits 2:0. The first advance after a load comes 2^(S+1)+2 edges after the load edge when strobes arrive every cycle.
- R8: The divider restarts from zero on every load and on every change of option bit 3, so a partial count never carries over.
- R9: An advance from 0xFF gives 0x00 and sets `ovf_flag`. The flag stays set until `ovf_clr` is sampled high. If a wrap and a clear happen in the same cycle, the flag is set.
- R10: With option bit 3 = 1, `wdt_tick` pulses for one cycle once per 2^(S+1) `cyc_en` strobes. With bit 3 = 0, `wdt_tick` stays 0.
- R11: A level change on `ext_pin` sampled at edge E0 advances the count at edge E0+4: two synchronizer flops, the edge compare, and the two-stage delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_en | input | 1 | Instruction-cycle strobe, one cycle wide |
| ext_pin | input | 1 | External count input, asynchronous |
| opt_cfg | input | 6 | Option word: source, edge, divider steering, ratio |
| wr_en | input | 1 | Load strobe for the count |
| wr_data | input | 8 | Value to load |
| rd_data | output | 8 | Present count |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky wrap indicator |
| wdt_tick | output | 1 | Divided watchdog tick, one cycle wide |

## Verification
The assertions run on every cycle. They check these properties:
- The count is frozen in both hold states.
- An unloaded count moves by zero or one per cycle.
- A load lands on the following edge.
- A wrap sets the flag and the flag stays set.
- Synchronized edge pulses, divider outputs and watchdog ticks are never two cycles wide.

The following can only be shown by the bench's scenarios, against a cycle-by-cycle reference model:
- The exact latency from pin or strobe to count.
- The divide ratios.
- The divider restart on a load and on a steering change.
- Edge-polarity selection.
- The tick rate for the watchdog.

// File: rtl/tcount_pkg.sv
`timescale 1ns/1ps
package tcount_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HOLD_A = 2'd1,
        ST_HOLD_B = 2'd2
    } hold_st_t;
endpackage

// File: rtl/tcount_edge_sync.sv
`timescale 1ns/1ps
module tcount_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_pulse
);
    logic [STAGES-1:0] sh_q;
    logic              last_q;
    logic              rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            last_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], pin};
            last_q <= sh_q[STAGES-1];
        end
    end

    always_comb begin
        rise       = sh_q[STAGES-1] & ~last_q;
        fall       = ~sh_q[STAGES-1] & last_q;
        edge_pulse = fall_sel ? fall : rise;
    end

    // R5: a synchronized rising edge is never two cycles wide
    p_edge_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    // R6: same for falling edges
    p_fall_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/tcount_prescaler.sv
`timescale 1ns/1ps
module tcount_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_timer,
    input  logic             src_wdt,
    input  logic             to_wdt,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic             clr,
    output logic             timer_pulse,
    output logic             wdt_tick
);
    localparam int PRE_W = 1 << SEL_W;

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] mask;
    logic             asg_q;
    logic             wdt_q;
    logic             restart, src, term, div_out;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i <= int'(ratio_sel));
        end
        restart     = clr | (asg_q != to_wdt);
        src         = to_wdt ? src_wdt : src_timer;
        term        = src && ((cnt_q & mask) == mask);
        div_out     = !to_wdt && !restart && term;
        timer_pulse = to_wdt ? src_timer : div_out;
        wdt_tick    = wdt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            asg_q <= 1'b0;
            wdt_q <= 1'b0;
        end else begin
            asg_q <= to_wdt;
            wdt_q <= to_wdt && !restart && term;
            if (restart) begin
                cnt_q <= '0;
            end else if (src) begin
                cnt_q <= term ? '0 : cnt_q + 1'b1;
            end
        end
    end

    // R7: divided output to the counter is never on two cycles in a row
    p_div_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out);
    // R10: watchdog tick is one cycle wide
    p_wdt_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_q |=> !wdt_q);
    // R8: a restart leaves the divider at zero
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt_q == '0);
endmodule

// File: rtl/tcount_hold_fsm.sv
`timescale 1ns/1ps
module tcount_hold_fsm
    import tcount_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic inc_ok
);
    hold_st_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:    st_d = ST_RUN;
            ST_HOLD_A: st_d = ST_HOLD_B;
            ST_HOLD_B: st_d = ST_RUN;
            default:   st_d = ST_RUN;
        endcase
        if (load) st_d = ST_HOLD_A;
    end

    always_comb begin
        inc_ok = (st_q == ST_RUN) && !load;
    end

    // R4: a load is followed by two hold states
    p_hold_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> st_q == ST_HOLD_A);
    p_hold_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD_A) && !load |=> st_q == ST_HOLD_B);
endmodule

// File: rtl/tcount_unit.sv
`timescale 1ns/1ps
module tcount_unit #(
    parameter int CNT_W   = 8,
    parameter int SEL_W   = 3,
    parameter int SYNC_N  = 2,
    parameter int INC_DLY = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cyc_en,
    input  logic                 ext_pin,
    input  logic [SEL_W+2:0]     opt_cfg,
    input  logic                 wr_en,
    input  logic [CNT_W-1:0]     wr_data,
    output logic [CNT_W-1:0]     rd_data,
    input  logic                 ovf_clr,
    output logic                 ovf_flag,
    output logic                 wdt_tick
);
    localparam int BIT_SRC  = SEL_W + 2;
    localparam int BIT_EDGE = SEL_W + 1;
    localparam int BIT_ASG  = SEL_W;

    logic             edge_pulse, src_timer, timer_pulse, inc_ok, inc_req, wrap;
    logic [INC_DLY-1:0] dly_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    tcount_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin),
        .fall_sel(opt_cfg[BIT_EDGE]), .edge_pulse(edge_pulse)
    );

    assign src_timer = opt_cfg[BIT_SRC] ? edge_pulse : cyc_en;

    tcount_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .src_timer(src_timer), .src_wdt(cyc_en),
        .to_wdt(opt_cfg[BIT_ASG]), .ratio_sel(opt_cfg[SEL_W-1:0]), .clr(wr_en),
        .timer_pulse(timer_pulse), .wdt_tick(wdt_tick)
    );

    tcount_hold_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .load(wr_en), .inc_ok(inc_ok)
    );

    generate
        if (INC_DLY == 1) begin : g_dly1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) dly_q <= '0;
                else        dly_q <= timer_pulse;
            end
        end else begin : g_dlyn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) dly_q <= '0;
                else        dly_q <= {dly_q[INC_DLY-2:0], timer_pulse};
            end
        end
    endgenerate

    assign inc_req = dly_q[INC_DLY-1];
    assign wrap    = inc_ok && inc_req && (cnt_q == {CNT_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (wr_en)                cnt_q <= wr_data;
            else if (inc_ok && inc_req) cnt_q <= cnt_q + 1'b1;
            if (wrap)                 ovf_q <= 1'b1;
            else if (ovf_clr)         ovf_q <= 1'b0;
        end
    end

    assign rd_data  = cnt_q;
    assign ovf_flag = ovf_q;

    // R2: a load lands on the next edge
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cnt_q == $past(wr_data));
    // R4: count frozen while the hold machine blocks advances
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_ok && !wr_en |=> $stable(cnt_q));
    // R3: without a load the count moves by at most one
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
    // R9: wrap gives zero and sets the flag
    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inc_ok && inc_req && (cnt_q == {CNT_W{1'b1}}) |=> ovf_q && (cnt_q == '0));
    // R9: flag is sticky until cleared
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q && !ovf_clr |=> ovf_q);
endmodule

// File: tb/tcount_unit_tb.sv
`timescale 1ns/1ps
module tcount_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0, ext_pin = 1'b0, wr_en = 1'b0, ovf_clr = 1'b0;
    logic [5:0] opt_cfg = 6'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ovf_flag, wdt_tick;

    int checks = 0, fails = 0, cyc = 0;
    string cur_req = "R1";

    // reference model state
    int m_p1, m_p2, m_pp, m_pc, m_cnt, m_hold, m_asg;
    int m_ovf, m_wdt;
    int m_dq[$];
    int e, sel, psrc, pout, tp, clr, n, inc, setv;

    always #2 clk = ~clk;

    tcount_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .opt_cfg(opt_cfg), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .wdt_tick(wdt_tick)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_p1 = 0; m_p2 = 0; m_pp = 0; m_pc = 0; m_cnt = 0; m_hold = 0;
            m_asg = 0; m_ovf = 0; m_wdt = 0;
            m_dq.delete(); m_dq.push_back(0); m_dq.push_back(0);
        end else begin
            e = opt_cfg[4] ? int'(m_pp == 1 && m_p2 == 0) : int'(m_p2 == 1 && m_pp == 0);
            m_pp = m_p2; m_p2 = m_p1; m_p1 = int'(ext_pin);
            sel  = opt_cfg[5] ? e : int'(cyc_en);
            clr  = int'(wr_en) | int'(int'(opt_cfg[3]) != m_asg);
            psrc = opt_cfg[3] ? int'(cyc_en) : sel;
            n    = 2 << opt_cfg[2:0];
            pout = 0;
            if (clr != 0) m_pc = 0;
            else if (psrc != 0) begin
                m_pc++;
                if (m_pc == n) begin pout = 1; m_pc = 0; end
            end
            m_wdt = opt_cfg[3] ? pout : 0;
            tp    = opt_cfg[3] ? sel : pout;
            inc   = m_dq.pop_front();
            m_dq.push_back(tp);
            setv  = 0;
            if (wr_en) begin m_cnt = int'(wr_data); m_hold = 2; end
            else if (m_hold > 0) m_hold--;
            else if (inc != 0) begin
                if (m_cnt == 255) begin m_cnt = 0; setv = 1; end
                else m_cnt++;
            end
            if (setv != 0) m_ovf = 1;
            else if (ovf_clr) m_ovf = 0;
            m_asg = int'(opt_cfg[3]);
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(int'(rd_data) == m_cnt, cur_req, int'(rd_data), m_cnt);
            check(int'(ovf_flag) == m_ovf, cur_req, int'(ovf_flag), m_ovf);
            check(int'(wdt_tick) == m_wdt, cur_req, int'(wdt_tick), m_wdt);
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            report();
        end
    end

    task automatic tick(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic load(logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        int cnt_t, edges;
        tick(3);
        check(rd_data == 8'h00 && !ovf_flag && !wdt_tick, "R1", int'(rd_data), 0);
        rst_n = 1'b1;
        tick(2);

        cur_req = "R2"; opt_cfg = 6'b001000;
        load(8'h5A);
        check(rd_data == 8'h5A, "R2", int'(rd_data), 8'h5A);

        cur_req = "R4"; cyc_en = 1'b1;
        load(8'h10);
        check(rd_data == 8'h10, "R4", int'(rd_data), 8'h10);
        tick(1); check(rd_data == 8'h10, "R4", int'(rd_data), 8'h10);
        tick(1); check(rd_data == 8'h10, "R4", int'(rd_data), 8'h10);
        tick(1); check(rd_data == 8'h11, "R3", int'(rd_data), 8'h11);
        tick(1); check(rd_data == 8'h12, "R3", int'(rd_data), 8'h12);

        cur_req = "R10"; opt_cfg = 6'b001001;
        load(8'h00);
        cnt_t = 0;
        for (int i = 0; i < 40; i++) begin tick(1); if (wdt_tick) cnt_t++; end
        check(cnt_t == 10, "R10", cnt_t, 10);

        cur_req = "R8"; opt_cfg = 6'b000001;
        for (int i = 0; i < 23; i++) begin cyc_en = 1'(($urandom % 2)); tick(1); end
        cyc_en = 1'b1;
        cur_req = "R7";
        load(8'h00);
        cnt_t = 0;
        for (int i = 0; i < 40; i++) begin tick(1); if (wdt_tick) cnt_t++; end
        check(rd_data == 8'd9, "R7 R8", int'(rd_data), 9);
        check(cnt_t == 0, "R10", cnt_t, 0);

        cur_req = "R11"; opt_cfg = 6'b101000; ext_pin = 1'b0;
        load(8'h00);
        tick(6);
        ext_pin = 1'b1;
        tick(4); check(rd_data == 8'h00, "R11", int'(rd_data), 0);
        tick(1); check(rd_data == 8'h01, "R11", int'(rd_data), 1);

        cur_req = "R5"; load(8'h00); tick(3); edges = 0;
        for (int i = 0; i < 20; i++) begin
            if (!ext_pin) edges++;
            ext_pin = ~ext_pin; tick(3);
        end
        tick(6);
        check(int'(rd_data) == edges, "R5", int'(rd_data), edges);

        cur_req = "R6"; opt_cfg = 6'b111000; load(8'h00); tick(3); edges = 0;
        for (int i = 0; i < 20; i++) begin
            if (ext_pin) edges++;
            ext_pin = ~ext_pin; tick(3);
        end
        tick(6);
        check(int'(rd_data) == edges, "R6", int'(rd_data), edges);

        cur_req = "R9"; opt_cfg = 6'b001000; cyc_en = 1'b1;
        load(8'hFE);
        tick(3); check(rd_data == 8'hFF, "R9", int'(rd_data), 8'hFF);
        tick(1); check(rd_data == 8'h00 && ovf_flag, "R9", int'(ovf_flag), 1);
        cyc_en = 1'b0; tick(10);
        check(ovf_flag == 1'b1, "R9", int'(ovf_flag), 1);
        ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0;
        check(ovf_flag == 1'b0, "R9", int'(ovf_flag), 0);

        cur_req = "R8";
        for (int i = 0; i < 800; i++) begin
            cyc_en  = 1'(($urandom % 2));
            if ($urandom % 4 == 0) ext_pin = ~ext_pin;
            ovf_clr = ($urandom % 16 == 0);
            if (i % 50 == 0) begin
                opt_cfg = 6'($urandom % 64);
                load(8'($urandom % 256));
            end else begin
                if (i % 37 == 0) opt_cfg[3] = ~opt_cfg[3];
                tick(1);
            end
        end
        ovf_clr = 1'b0;
        tick(2);
        report();
    end
endmodule